// File: doc/BRIEF.md
# Configurable NMI Trigger Latch

This block takes one external non-maskable interrupt pad, which may be asynchronous to the system clock, and turns it into a sticky request. The request is always active-high and level-sensitive, and it is meant for a downstream interrupt controller. A two-bit sense mode picks how the pad is interpreted: low level, falling edge, high level or rising edge. The pad first passes through a multi-flop synchronizer. Polarity and edge qualification are then applied, and any qualifying condition sets a set/reset latch.

Software observes the latch as pending bit 0. It clears the latch by writing 1 to that bit. The latch drives the interrupt request directly, whatever the pad mode is, so the downstream controller is always programmed for a level-high input. A separate wake output is the latch gated by enable bit 0.

Top module: `nmi_trigger_latch`

## Requirements
- R1: While reset is asserted and right after it, mode reads 0, enable reads 0, and pending, irq_o and wake_o are all 0.
- R2: Level modes use code 0 to set the latch while the synchronized pad is low, and code 2 to set it while the synchronized pad is high.
- R3: Edge modes use code 1 to set the latch on a high-to-low transition and code 3 to set it on a low-to-high transition. A steady pad level never sets the latch in an edge mode.
- R4: Once set, the latch stays set after the pad condition goes away, until software clears it.
- R5: A pending write with wr_data_i bit 0 = 1 clears the latch. A pending write with bit 0 = 0 leaves it unchanged.
- R6: If a set condition and a clear write fall in the same cycle, the latch ends up set. In a level mode, a clear issued while the pad is still at its active level therefore leaves pending at 1.
- R7: irq_o equals the latch state in every cycle and is active-high in all four modes.
- R8: wake_o is 1 exactly when the latch is set and enable bit 0 is 1.
- R9: Writing an edge mode while the pad is held steady does not set the latch, because the edge history always holds the current synchronized level.
- R10: When the pad changes just before clock edge k, pending reflects the change after edge k+2, which is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | 1 | External interrupt pad, asynchronous |
| wr_data_i | input | 2 | Write data: bits 1:0 are the mode, bit 0 is also the clear and enable value |
| mode_we_i | input | 1 | Write strobe for the sense-mode register |
| pend_we_i | input | 1 | Write strobe for the pending register (write-1-to-clear) |
| en_we_i | input | 1 | Write strobe for enable bit 0 |
| mode_o | output | 2 | Current sense mode |
| pending_o | output | 1 | Pending bit 0, the latch state |
| enable_o | output | 1 | Enable bit 0 |
| irq_o | output | 1 | Level-high request to the downstream controller |
| wake_o | output | 1 | Latch gated by enable bit 0 |

## Verification
The hardest case to reach from the ports is a qualifying edge that lands in the very cycle a clear is written. The edge is only visible two flops after the pad moves. The stimulus therefore raises the pad on a falling clock edge and counts two rising edges before it asserts the clear strobe for exactly one cycle. A full sweep over all four modes and all four pad start/end level pairs then compares pending, irq and wake against values computed from the mode code, with the enable toggled across the sweep.

// File: rtl/nmi_latch_pkg.sv
package nmi_latch_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_FALL   = 2'd1,
    SENSE_LVL_HI = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_mode_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_sense.sv
module nmi_sense
  import nmi_latch_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lvl_i,
  input  sense_mode_t mode_i,
  output logic        evt_o
);
  // Edge history: always the synchronized level of the previous cycle,
  // so a mode change never creates a false edge.
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= lvl_i;
  end

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LO: evt_o = ~lvl_i;
      SENSE_FALL:   evt_o = hist_q & ~lvl_i;
      SENSE_LVL_HI: evt_o = lvl_i;
      SENSE_RISE:   evt_o = ~hist_q & lvl_i;
      default:      evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_hold.sv
module nmi_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic hold_q;
  logic hold_d;

  // Set dominates clear.
  always_comb begin
    hold_d = hold_q;
    if (clr_i) hold_d = 1'b0;
    if (set_i) hold_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/nmi_trigger_latch.sv
module nmi_trigger_latch
  import nmi_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pad_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  logic              mode_we_i,
  input  logic              pend_we_i,
  input  logic              en_we_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              pending_o,
  output logic              enable_o,
  output logic              irq_o,
  output logic              wake_o
);
  sense_mode_t mode_q, mode_d;
  logic        en_q, en_d;
  logic        pad_sync;
  logic        sense_evt;
  logic        pend_clr;
  logic        latch_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_we_i) mode_d = sense_mode_t'(wr_data_i);
    en_d = en_q;
    if (en_we_i) en_d = wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SENSE_LVL_LO;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  nmi_sense u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pad_sync),
    .mode_i (mode_q),
    .evt_o  (sense_evt)
  );

  assign pend_clr = pend_we_i & wr_data_i[0];

  nmi_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sense_evt),
    .clr_i  (pend_clr),
    .q_o    (latch_q)
  );

  assign mode_o    = mode_q;
  assign enable_o  = en_q;
  assign pending_o = latch_q;
  assign irq_o     = latch_q;
  assign wake_o    = latch_q & en_q;
endmodule

// File: rtl/nmi_trigger_latch_chk.sv
module nmi_trigger_latch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic evt_i,
  input logic clr_i,
  input logic pending_i,
  input logic irq_i
);
  // R6
  set_dominates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pending_i);
  // R5
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !pending_i);
  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && !clr_i) |=> pending_i);
  // R3
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_i && !evt_i) |=> !pending_i);
  // R7
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(evt_i));
endmodule

bind nmi_trigger_latch nmi_trigger_latch_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (sense_evt),
  .clr_i     (pend_clr),
  .pending_i (pending_o),
  .irq_i     (irq_o)
);

// File: tb/nmi_trigger_latch_bench.sv
module nmi_trigger_latch_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pad_i = 1'b0;
  logic [1:0] wr_data_i = '0;
  logic       mode_we_i = 1'b0;
  logic       pend_we_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [1:0] mode_o;
  logic       pending_o, enable_o, irq_o, wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  nmi_trigger_latch u_nmi_trigger_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_i), .wr_data_i(wr_data_i),
    .mode_we_i(mode_we_i), .pend_we_i(pend_we_i), .en_we_i(en_we_i),
    .mode_o(mode_o), .pending_o(pending_o), .enable_o(enable_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk_i); mode_we_i = 1'b1; wr_data_i = m;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic wr_pend(input logic b);
    @(negedge clk_i); pend_we_i = 1'b1; wr_data_i = {1'b0, b};
    @(negedge clk_i); pend_we_i = 1'b0;
  endtask

  task automatic wr_en(input logic b);
    @(negedge clk_i); en_we_i = 1'b1; wr_data_i = {1'b0, b};
    @(negedge clk_i); en_we_i = 1'b0;
  endtask

  function automatic int lvl_act(input int m, input int x);
    return ((m == 0 && x == 0) || (m == 2 && x == 1)) ? 1 : 0;
  endfunction

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) disable watchdog;
    end
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1 pending", pending_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 enable", enable_o, 0);
    chk("R1 wake", wake_o, 0);
    pad_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 irq after release", irq_o, 0);

    // Sweep: mode x start level x end level (R2 R3 R4 R7 R8)
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          int en, exp;
          en = (m + a + b) % 2;
          @(negedge clk_i); pad_i = a[0];
          tick(4);
          wr_mode(m[1:0]);
          chk("R2 mode readback", mode_o, m);
          tick(3);
          wr_pend(1'b1);
          chk("R6 clear vs active level", pending_o, lvl_act(m, a));
          wr_en(en[0]);
          @(negedge clk_i); pad_i = b[0];
          tick(5);
          exp = lvl_act(m, a) | lvl_act(m, b) |
                ((m == 3 && a == 0 && b == 1) ? 1 : 0) |
                ((m == 1 && a == 1 && b == 0) ? 1 : 0);
          chk((m % 2) ? "R3 edge sense" : "R2 level sense", pending_o, exp);
          chk("R7 irq equals latch", irq_o, exp);
          chk("R8 wake gating", wake_o, exp & en);
        end
      end
    end

    // R4 / R5: sticky, write 0 ignored, write 1 clears
    wr_mode(2'd3);
    @(negedge clk_i); pad_i = 1'b0; tick(4);
    wr_pend(1'b1);
    @(negedge clk_i); pad_i = 1'b1; tick(4);
    @(negedge clk_i); pad_i = 1'b0; tick(4);
    chk("R4 sticky after pad returns", pending_o, 1);
    wr_pend(1'b0);
    chk("R5 write 0 ignored", pending_o, 1);
    wr_pend(1'b1);
    chk("R5 write 1 clears", pending_o, 0);

    // R9: edge mode written while pad steady high
    @(negedge clk_i); pad_i = 1'b1; tick(4);
    wr_mode(2'd0);
    wr_pend(1'b1);
    wr_mode(2'd3);
    tick(4);
    chk("R9 mode write no set", pending_o, 0);

    // R10 latency in mode 2
    @(negedge clk_i); pad_i = 1'b0; tick(4);
    wr_mode(2'd2);
    wr_pend(1'b1);
    chk("R10 cleared before", pending_o, 0);
    @(negedge clk_i); pad_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 not yet after two edges", pending_o, 0);
    @(negedge clk_i);
    chk("R10 set after third edge", pending_o, 1);

    // R6: rising edge and clear in the same cycle
    wr_mode(2'd3);
    @(negedge clk_i); pad_i = 1'b0; tick(4);
    wr_pend(1'b1);
    chk("R6 precondition clear", pending_o, 0);
    @(negedge clk_i); pad_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); pend_we_i = 1'b1; wr_data_i = 2'd1;
    @(negedge clk_i); pend_we_i = 1'b0;
    chk("R6 set wins over clear", pending_o, 1);
    wr_pend(1'b1);
    chk("R6 later clear works", pending_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule